// File: doc/BRIEF.md
# Eight-Key Parallel Debouncer

This block cleans up eight mechanical key contacts at once. The key pins are active-low and arrive asynchronously. Each pin first passes through a short synchronizer. A divider derived from the system clock produces a single-cycle sample enable, at 200 Hz by default. On each enable the block compares every synchronized key against its current debounced level.

Each key has a 2-bit disagreement counter. The eight counters are not stored separately: they are held as two 8-bit bit-plane registers, one for the low counter bits and one for the high counter bits. Plain bitwise logic updates all eight keys together. A key's debounced level flips only after four consecutive samples that disagree with it. A single agreeing sample restarts that key's count.

Whenever a key's debounced level rises, the block sets a sticky press flag for that key. A consumer acknowledges flags with a one-cycle clear strobe and a bit mask.

Top module: `keyDebounce8`

## Requirements
- R1: While reset is asserted, and right after it, keyLevel and keyPressed read all zeros.
- R2: Bit k of every bus belongs to key k. A low on keyPinN[k] means pressed, and keyLevel[k]=1 means debounced pressed.
- R3: Keys are examined only on the sample enable, which fires once every CLK_HZ/TICK_HZ clock cycles. keyLevel never changes between enables, and a pin pulse that starts and ends between two enables has no effect.
- R4: A key's level flips on the fourth consecutive sample that disagrees with it. Three disagreeing samples leave it unchanged.
- R5: A sample that agrees with the current level restarts that key's count, so a bouncing contact needs four fresh disagreeing samples.
- R6: Every key counts on its own, so keys that started disagreeing on different samples flip on their own fourth samples.
- R7: A release (level going from 1 to 0) follows the same four-sample rule and sets no press flag.
- R8: keyPressed[k] becomes 1 on the same clock edge where keyLevel[k] goes from 0 to 1. It then stays at 1 until it is cleared.
- R9: A one-cycle clrStrobe clears exactly the keyPressed bits that are set in clrMask. All other bits are kept.
- R10: If a clear and a new press hit the same bit on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyPinN | input | 8 | Raw key contacts, low means pressed |
| clrStrobe | input | 1 | One-cycle request to clear press flags |
| clrMask | input | 8 | Press flags to clear when clrStrobe is high |
| keyLevel | output | 8 | Debounced key levels, 1 means pressed |
| keyPressed | output | 8 | Sticky press flags |

## Verification
The divider restarts at zero on reset, so the sample enables fall on every CLK_HZ/TICK_HZ-th edge after reset is released. The bench counts edges itself and takes each reading on the falling edge that follows an enable edge, which is when a new level and a new press flag become visible. Pin changes are applied just after an enable edge, so they have crossed the two synchronizer flops well before the next enable. Clears are sent either early in the window or in the cycle just before the enable edge, which is how the coincident-clear case is hit. A pin pulse that returns before the synchronizer output is used must leave every output unchanged.

// File: rtl/kdb_pkg.sv
package kdb_pkg;

  // strobes handed from the control side to the datapath
  typedef struct packed {
    logic tick;    // one-cycle sample enable
    logic clrEn;   // press-flag clear request for this cycle
  } kdbStrobe_t;

  function automatic int unsigned divWidth(input int unsigned div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction

endpackage

// File: rtl/kdb_ctrl.sv
module kdb_ctrl
  import kdb_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 4000000,
  parameter int unsigned TICK_HZ = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clrStrobe,
  output kdbStrobe_t strb
);

  localparam int unsigned DIV = (CLK_HZ / TICK_HZ > 1) ? CLK_HZ / TICK_HZ : 2;
  localparam int unsigned CW  = divWidth(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] divCnt;
  logic          tickNow;

  assign tickNow = (divCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (tickNow) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strb       = '0;
    strb.tick  = tickNow;
    strb.clrEn = clrStrobe;
  end

  // R3: the enable is a single-cycle pulse
  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> !strb.tick);

  // R3: after an enable the divider restarts from zero
  a_r3_div_restart: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> (divCnt == '0));

endmodule

// File: rtl/kdb_datapath.sv
module kdb_datapath
  import kdb_pkg::*;
#(
  parameter int unsigned NKEYS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  kdbStrobe_t       strb,
  input  logic [NKEYS-1:0] keyPinN,
  input  logic [NKEYS-1:0] clrMask,
  output logic [NKEYS-1:0] levelQ,
  output logic [NKEYS-1:0] pressQ
);

  logic [SYNC_STAGES-1:0][NKEYS-1:0] syncQ;

  // synchronizer chain, idle value is "released" (high)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '1;
    else       syncQ[0] <= keyPinN;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '1;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  logic [NKEYS-1:0] pressedRaw, changed;
  logic [NKEYS-1:0] lowQ, highQ, lowNext, highNext;
  logic [NKEYS-1:0] rollOver, levelNext, pressSet, clrBits;
  logic             tickEn;

  assign tickEn     = strb.tick;
  assign pressedRaw = ~syncQ[SYNC_STAGES-1];
  assign changed    = levelQ ^ pressedRaw;

  // vertical 2-bit counters: agreeing keys snap to 3, disagreeing keys count down
  assign lowNext   = ~(lowQ & changed);
  assign highNext  = lowNext ^ (highQ & changed);
  assign rollOver  = changed & lowNext & highNext;
  assign levelNext = levelQ ^ rollOver;
  assign pressSet  = tickEn ? (rollOver & levelNext) : '0;
  assign clrBits   = strb.clrEn ? clrMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowQ   <= '1;
      highQ  <= '1;
      levelQ <= '0;
    end else if (tickEn) begin
      lowQ   <= lowNext;
      highQ  <= highNext;
      levelQ <= levelNext;
    end
  end

  // clear first, new presses on top: a coincident set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pressQ <= '0;
    else       pressQ <= (pressQ & ~clrBits) | pressSet;
  end

  // R3: level moves only on a sample enable
  a_r3_level_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(levelQ));

  // R8: a new flag appears only with an enable
  a_r8_flag_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (|(pressQ & ~$past(pressQ))) |-> $past(tickEn));

  // R8: every new flag comes with a rising level on the same key
  a_r8_flag_needs_rise: assert property (@(posedge clk) disable iff (!rstN)
    ((pressQ & ~$past(pressQ)) & ~(levelQ & ~$past(levelQ))) == '0);

  // R9: a flag can only drop where the mask asked for it
  a_r9_clear_masked: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pressQ) & ~pressQ & ~($past(clrMask) & {NKEYS{$past(strb.clrEn)}})) == '0);

endmodule

// File: rtl/keyDebounce8.sv
module keyDebounce8
  import kdb_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 4000000,
  parameter int unsigned TICK_HZ     = 200,
  parameter int unsigned NKEYS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NKEYS-1:0] keyPinN,
  input  logic             clrStrobe,
  input  logic [NKEYS-1:0] clrMask,
  output logic [NKEYS-1:0] keyLevel,
  output logic [NKEYS-1:0] keyPressed
);

  kdbStrobe_t strb;

  kdb_ctrl #(
    .CLK_HZ (CLK_HZ),
    .TICK_HZ(TICK_HZ)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clrStrobe(clrStrobe),
    .strb     (strb)
  );

  kdb_datapath #(
    .NKEYS      (NKEYS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .keyPinN(keyPinN),
    .clrMask(clrMask),
    .levelQ (keyLevel),
    .pressQ (keyPressed)
  );

  // R1: outputs are zero while reset is held
  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |-> (keyLevel == '0 && keyPressed == '0));

endmodule

// File: tb/sim_keyDebounce8.sv
module sim_keyDebounce8;

  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] keyPinN = 8'hFF;
  logic       clrStrobe = 1'b0;
  logic [7:0] clrMask = 8'h00;
  logic [7:0] keyLevel, keyPressed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  keyDebounce8 #(.CLK_HZ(1600), .TICK_HZ(200)) u0 (
    .clk(clk), .rstN(rstN), .keyPinN(keyPinN), .clrStrobe(clrStrobe),
    .clrMask(clrMask), .keyLevel(keyLevel), .keyPressed(keyPressed));

  // vector layout: {glitch[25:18], clrAtTick[17], clr[16], mask[15:8], pinsN[7:0]}
  localparam int NV = 30;
  localparam logic [25:0] VEC [NV] = '{
    {8'h00,1'b0,1'b0,8'h00,8'hFF},  // 0 idle
    {8'h00,1'b0,1'b0,8'h00,8'hFE},  // 1..4 key0 pressed
    {8'h00,1'b0,1'b0,8'h00,8'hFE},
    {8'h00,1'b0,1'b0,8'h00,8'hFE},
    {8'h00,1'b0,1'b0,8'h00,8'hFE},
    {8'h00,1'b0,1'b0,8'h00,8'hFC},  // 5..11 key1 with bounce
    {8'h00,1'b0,1'b0,8'h00,8'hFC},
    {8'h00,1'b0,1'b0,8'h00,8'hFE},
    {8'h00,1'b0,1'b0,8'h00,8'hFC},
    {8'h00,1'b0,1'b0,8'h00,8'hFC},
    {8'h00,1'b0,1'b0,8'h00,8'hFC},
    {8'h00,1'b0,1'b0,8'h00,8'hFC},
    {8'h00,1'b0,1'b1,8'h01,8'hFC},  // 12 clear key0 flag only
    {8'h10,1'b0,1'b0,8'h00,8'hFC},  // 13..14 short pulse on key4
    {8'h10,1'b0,1'b0,8'h00,8'hFC},
    {8'h00,1'b0,1'b0,8'h00,8'hFD},  // 15..18 key0 released
    {8'h00,1'b0,1'b0,8'h00,8'hFD},
    {8'h00,1'b0,1'b0,8'h00,8'hFD},
    {8'h00,1'b0,1'b0,8'h00,8'hFD},
    {8'h00,1'b0,1'b0,8'h00,8'hF9},  // 19..22 key2 press, clear at its edge
    {8'h00,1'b0,1'b0,8'h00,8'hF9},
    {8'h00,1'b0,1'b0,8'h00,8'h79},
    {8'h00,1'b1,1'b1,8'h06,8'h79},
    {8'h00,1'b0,1'b0,8'h00,8'h79},  // 23..24 key7 reaches its fourth sample
    {8'h00,1'b0,1'b0,8'h00,8'h79},
    {8'h00,1'b0,1'b1,8'hFF,8'h79},  // 25 clear all flags
    {8'h00,1'b0,1'b0,8'h00,8'hFF},  // 26..29 release all
    {8'h00,1'b0,1'b0,8'h00,8'hFF},
    {8'h00,1'b0,1'b0,8'h00,8'hFF},
    {8'h00,1'b0,1'b0,8'h00,8'hFF}
  };

  function automatic string tagOf(input int i);
    if (i == 0)       return "R2";
    else if (i <= 4)  return "R4";
    else if (i <= 11) return "R5";
    else if (i == 12) return "R9";
    else if (i <= 14) return "R3";
    else if (i <= 18) return "R7";
    else if (i <= 22) return "R10";
    else if (i <= 24) return "R6";
    else if (i == 25) return "R9";
    else              return "R7";
  endfunction

  // bench reference state
  logic [7:0] mLevel = 8'h00;
  logic [7:0] mFlags = 8'h00;
  int         mCnt [8];

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // one sample window; enters and leaves on a falling edge right after an enable edge
  task automatic runWindow(input logic [25:0] v, input string tag);
    logic [7:0] pins, mask, glitch;
    logic clr, atTick;
    pins = v[7:0]; mask = v[15:8]; clr = v[16]; atTick = v[17]; glitch = v[25:18];
    keyPinN = pins;
    if (clr && !atTick) begin clrStrobe = 1'b1; clrMask = mask; end
    for (int c = 1; c <= DIV; c++) begin
      @(posedge clk);
      @(negedge clk);
      clrStrobe = 1'b0;
      if (c == 1 && glitch != 0) keyPinN = pins ^ glitch;
      if (c == 3) keyPinN = pins;
      if (c == DIV - 1 && clr && atTick) begin clrStrobe = 1'b1; clrMask = mask; end
    end
    clrStrobe = 1'b0;
    // reference: clear, then count disagreeing samples per key
    if (clr) mFlags = mFlags & ~mask;
    for (int k = 0; k < 8; k++) begin
      if ((~pins[k]) != mLevel[k]) begin
        mCnt[k]++;
        if (mCnt[k] == 4) begin
          mCnt[k] = 0;
          mLevel[k] = ~mLevel[k];
          if (mLevel[k]) mFlags[k] = 1'b1;
        end
      end else begin
        mCnt[k] = 0;
      end
    end
    check8({tag, " level"}, keyLevel, mLevel);
    check8({"R8 flags ", tag}, keyPressed, mFlags);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++) mCnt[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check8("R1 reset level", keyLevel, 8'h00);
    check8("R1 reset flags", keyPressed, 8'h00);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) runWindow(VEC[i], tagOf(i));
    // reset in the middle of activity
    for (int i = 0; i < 4; i++) runWindow({8'h00,1'b0,1'b0,8'h00,8'h7E}, "R2 press");
    check8("R2 both pressed", keyLevel, 8'h81);
    rstN = 1'b0;
    #1;
    check8("R1 async level", keyLevel, 8'h00);
    check8("R1 async flags", keyPressed, 8'h00);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

endmodule